// File: doc/BRIEF.md
# SPI Host Segment Engine

This block is a single-lane SPI master in mode 0. Software queues transfer segments into a small command queue. Each segment gives a byte count, whether bytes are sent, whether bytes are captured, and whether chip-select stays low after the segment ends. Outgoing bytes are taken from a TX FIFO, most significant bit first. Captured bytes are pushed into an RX FIFO. The serial clock is divided down from the system clock.

The engine never drops or repeats data when a FIFO cannot keep up. Before each byte it checks whether the byte can be carried out. If the segment sends data and the TX FIFO is empty, or the segment captures data and the RX FIFO is full, the engine waits on that byte boundary. While it waits, the serial clock stays low and chip-select stays low, and a stall flag is raised. It continues when the host writes data or frees space.

A segment marked keep-select leaves chip-select low when it ends. If no further segment is queued, the engine rests in a hold state and waits there for as long as needed. The next segment then starts without releasing the device. A segment without that mark releases chip-select after its last byte.

Top module: `spi_seg_engine`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, every FIFO and the command queue are emptied. The outputs then read: csb=1, sck=0, sd_o=0, both stall flags 0, hold_idle=0, tx_qd=0 and rx_qd=0.
- R2: Mode 0 timing. sck idles at 0. While a byte shifts, sck toggles every `cfg_div+1` clock cycles. The first rising edge comes `cfg_div+1` cycles after the byte is loaded. sd_o shows the current byte MSB first and changes only when sck falls or when a new byte is loaded. sd_i is captured on the rising edges.
- R3: `cmd_len` holds the byte count minus one. When `cmd_tx` is 1, one TX FIFO byte is consumed per byte shifted; otherwise zeros are shifted out. When `cmd_rx` is 1, each received byte is pushed into the RX FIFO after its eighth falling sck edge. Segments run in the order they were queued.
- R4: If a capturing segment reaches a byte boundary with the RX FIFO full, the engine stalls. From the next cycle rx_stall=1, sck=0 and csb=0. The byte starts once space exists, and the received stream has no lost or repeated bits.
- R5: If a sending segment reaches a byte boundary with the TX FIFO empty, the engine stalls. From the next cycle tx_stall=1, sck=0 and csb=0. Shifting resumes after a TX write, with the new byte.
- R6: A segment with `cmd_keep`=1 that finds the queue empty at its end enters hold. There hold_idle=1, csb=0 and sck=0 for an unlimited time, and the next queued segment starts without csb rising.
- R7: A segment with `cmd_keep`=0 sets csb to 1 in the cycle after its last falling sck edge. The engine is then idle.
- R8: `tx_wm` is 1 exactly when the TX FIFO occupancy is below `cfg_txwm`.
- R9: `tx_qd` and `rx_qd` report the FIFO occupancies. `tx_empty` is 1 when tx_qd is 0, and `rx_full` is 1 when rx_qd equals the RX depth.
- R10: `tx_wready` and `cmd_ready` drop when their store is full, and a write offered while full is discarded. `rx_rvalid` with `rx_rdata` presents the oldest received byte, which is removed by `rx_rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | DIV_W | Half sck period minus one, in clocks |
| cfg_txwm | input | TXC | TX watermark level |
| cmd_valid | input | 1 | Offer a segment |
| cmd_len | input | LEN_W | Segment byte count minus one |
| cmd_tx | input | 1 | Segment sends TX FIFO bytes |
| cmd_rx | input | 1 | Segment captures bytes |
| cmd_keep | input | 1 | Keep chip-select low after the segment |
| cmd_ready | output | 1 | Command queue has room |
| tx_wvalid | input | 1 | TX FIFO write strobe |
| tx_wdata | input | 8 | TX FIFO write byte |
| tx_wready | output | 1 | TX FIFO has room |
| rx_rready | input | 1 | Remove the RX FIFO head |
| rx_rvalid | output | 1 | RX FIFO holds a byte |
| rx_rdata | output | 8 | RX FIFO head byte |
| sck | output | 1 | Serial clock |
| csb | output | 1 | Chip-select, active low |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |
| tx_qd | output | TXC | TX FIFO occupancy |
| rx_qd | output | RXC | RX FIFO occupancy |
| tx_empty | output | 1 | TX FIFO empty |
| rx_full | output | 1 | RX FIFO full |
| tx_wm | output | 1 | TX occupancy below watermark |
| tx_stall | output | 1 | Waiting for TX data |
| rx_stall | output | 1 | Waiting for RX space |
| hold_idle | output | 1 | Idle with chip-select held low |

## Verification
A wrong phase or divider count shows on sck or sd_o within one half period. A miscounted byte or segment length moves the csb rise or the hold entry by at least a half period. Those pins are compared against a reference on every clock, so these faults surface within a few cycles. A stall decided from the wrong FIFO level shows one cycle after the byte boundary: either a stall flag appears with sck still moving, or data appears in the wrong FIFO slot, which is seen at rx_rdata as soon as the host reads that entry.

// File: rtl/spi_seg_engine.sv
module spi_seg_engine #(
  parameter int TX_DEPTH  = 8,
  parameter int RX_DEPTH  = 4,
  parameter int CMD_DEPTH = 2,
  parameter int LEN_W     = 4,
  parameter int DIV_W     = 4,
  localparam int TXC = $clog2(TX_DEPTH + 1),
  localparam int RXC = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [TXC-1:0]   cfg_txwm,
  input  logic             cmd_valid,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_tx,
  input  logic             cmd_rx,
  input  logic             cmd_keep,
  output logic             cmd_ready,
  input  logic             tx_wvalid,
  input  logic [7:0]       tx_wdata,
  output logic             tx_wready,
  input  logic             rx_rready,
  output logic             rx_rvalid,
  output logic [7:0]       rx_rdata,
  output logic             sck,
  output logic             csb,
  output logic             sd_o,
  input  logic             sd_i,
  output logic [TXC-1:0]   tx_qd,
  output logic [RXC-1:0]   rx_qd,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             tx_wm,
  output logic             tx_stall,
  output logic             rx_stall,
  output logic             hold_idle
);
  localparam int TXA = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int RXA = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int CQA = (CMD_DEPTH > 1) ? $clog2(CMD_DEPTH) : 1;
  localparam int CQC = $clog2(CMD_DEPTH + 1);
  localparam int CW  = LEN_W + 3;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_HOLD} state_t;
  state_t state;

  logic [7:0]       tx_mem [TX_DEPTH];
  logic [TXA-1:0]   tx_wp, tx_rp;
  logic [TXC-1:0]   tx_cnt;
  logic [7:0]       rx_mem [RX_DEPTH];
  logic [RXA-1:0]   rx_wp, rx_rp;
  logic [RXC-1:0]   rx_cnt;
  logic [CW-1:0]    cq_mem [CMD_DEPTH];
  logic [CQA-1:0]   cq_wp, cq_rp;
  logic [CQC-1:0]   cq_cnt;

  logic [LEN_W-1:0] seg_left;
  logic             seg_tx, seg_rx, seg_keep;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       tx_sr, rx_sr;

  logic tx_push, tx_pop, rx_push, rx_pop, cq_push, cq_pop;
  logic starve, choke, go, half, byte_end;

  assign tx_wready = tx_cnt != TXC'(TX_DEPTH);
  assign cmd_ready = cq_cnt != CQC'(CMD_DEPTH);
  assign rx_rvalid = rx_cnt != '0;
  assign rx_rdata  = rx_mem[rx_rp];
  assign tx_push   = tx_wvalid && tx_wready;
  assign rx_pop    = rx_rready && rx_rvalid;
  assign cq_push   = cmd_valid && cmd_ready;

  assign cq_pop   = (state == S_IDLE || state == S_HOLD) && cq_cnt != '0;
  assign starve   = seg_tx && tx_cnt == '0;
  assign choke    = seg_rx && rx_cnt == RXC'(RX_DEPTH);
  assign go       = state == S_LOAD && !starve && !choke;
  assign tx_pop   = go && seg_tx;
  assign half     = state == S_SHIFT && div_cnt == cfg_div;
  assign byte_end = half && sck && bit_cnt == 3'd7;
  assign rx_push  = byte_end && seg_rx;

  assign csb       = state == S_IDLE;
  assign hold_idle = state == S_HOLD;
  assign sd_o      = tx_sr[7];
  assign tx_qd     = tx_cnt;
  assign rx_qd     = rx_cnt;
  assign tx_empty  = tx_cnt == '0;
  assign rx_full   = rx_cnt == RXC'(RX_DEPTH);
  assign tx_wm     = tx_cnt < cfg_txwm;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_sr;
    if (cq_push) cq_mem[cq_wp] <= {cmd_keep, cmd_rx, cmd_tx, cmd_len};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      cq_wp <= '0; cq_rp <= '0; cq_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == TXA'(TX_DEPTH - 1)) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == TXA'(TX_DEPTH - 1)) ? '0 : tx_rp + 1'b1;
      if (rx_push) rx_wp <= (rx_wp == RXA'(RX_DEPTH - 1)) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == RXA'(RX_DEPTH - 1)) ? '0 : rx_rp + 1'b1;
      if (cq_push) cq_wp <= (cq_wp == CQA'(CMD_DEPTH - 1)) ? '0 : cq_wp + 1'b1;
      if (cq_pop)  cq_rp <= (cq_rp == CQA'(CMD_DEPTH - 1)) ? '0 : cq_rp + 1'b1;
      tx_cnt <= tx_cnt + TXC'(tx_push) - TXC'(tx_pop);
      rx_cnt <= rx_cnt + RXC'(rx_push) - RXC'(rx_pop);
      cq_cnt <= cq_cnt + CQC'(cq_push) - CQC'(cq_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sck      <= 1'b0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      seg_left <= '0;
      seg_tx   <= 1'b0;
      seg_rx   <= 1'b0;
      seg_keep <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      tx_stall <= 1'b0;
      rx_stall <= 1'b0;
    end else begin
      tx_stall <= state == S_LOAD && starve;
      rx_stall <= state == S_LOAD && choke;
      case (state)
        S_IDLE, S_HOLD: begin
          if (cq_pop) begin
            {seg_keep, seg_rx, seg_tx, seg_left} <= cq_mem[cq_rp];
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (go) begin
            tx_sr   <= seg_tx ? tx_mem[tx_rp] : 8'h00;
            div_cnt <= '0;
            bit_cnt <= '0;
            state   <= S_SHIFT;
          end
        end
        default: begin
          if (half) begin
            div_cnt <= '0;
            sck     <= ~sck;
            if (!sck) begin
              rx_sr <= {rx_sr[6:0], sd_i};
            end else begin
              tx_sr   <= {tx_sr[6:0], 1'b0};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                if (seg_left == '0) begin
                  state <= seg_keep ? S_HOLD : S_IDLE;
                end else begin
                  seg_left <= seg_left - 1'b1;
                  state    <= S_LOAD;
                end
              end
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module spi_seg_engine_chk #(
  parameter int TX_DEPTH = 8,
  localparam int TXC = $clog2(TX_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sck,
  input logic           csb,
  input logic           sd_o,
  input logic           rx_stall,
  input logic           tx_stall,
  input logic           hold_idle,
  input logic           rx_full,
  input logic           tx_empty,
  input logic [TXC-1:0] tx_qd
);
  a_r2_sdo_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(sd_o));
  a_r4_rx_stall_pins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stall |-> (!sck && !csb));
  a_r4_rx_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_stall) |-> $past(rx_full));
  a_r5_tx_stall_pins: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stall |-> (!sck && !csb));
  a_r5_tx_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_stall) |-> $past(tx_empty));
  a_r6_hold_pins: assert property (@(posedge clk) disable iff (!rst_n)
    hold_idle |-> (!csb && !sck));
  a_r7_release_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csb) |-> !sck);
  a_r10_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_qd <= TXC'(TX_DEPTH));
endmodule

bind spi_seg_engine spi_seg_engine_chk #(.TX_DEPTH(TX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .sd_o(sd_o),
  .rx_stall(rx_stall), .tx_stall(tx_stall), .hold_idle(hold_idle),
  .rx_full(rx_full), .tx_empty(tx_empty), .tx_qd(tx_qd)
);

// File: tb/spi_seg_engine_bench.sv
module spi_seg_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 8, RXD = 4, CQD = 2, LW = 4, DW = 4;
  localparam int TXC = $clog2(TXD + 1), RXC = $clog2(RXD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] cfg_div = 1;
  logic [TXC-1:0] cfg_txwm = 3;
  logic cmd_valid = 0, cmd_tx = 0, cmd_rx = 0, cmd_keep = 0, cmd_ready;
  logic [LW-1:0] cmd_len = 0;
  logic tx_wvalid = 0, tx_wready, rx_rready = 0, rx_rvalid;
  logic [7:0] tx_wdata = 0, rx_rdata;
  logic sck, csb, sd_o, sd_i = 0;
  logic [TXC-1:0] tx_qd;
  logic [RXC-1:0] rx_qd;
  logic tx_empty, rx_full, tx_wm, tx_stall, rx_stall, hold_idle;

  spi_seg_engine #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .CMD_DEPTH(CQD), .LEN_W(LW), .DIV_W(DW))
  u_spi_seg_engine (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0, drain = 0;
  bit saw_rxst = 0, saw_txst = 0, saw_hold = 0, saw_cmdfull = 0;
  int rx_got = 0, idx = 0;
  logic prev_sck = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model
  int txq[$], rxq[$], cmq[$];
  int m_state = 0, m_sck = 0, m_div = 0, m_bit = 0, m_left = 0;
  int m_tx = 0, m_rx = 0, m_keep = 0, m_txsr = 0, m_rxsr = 0, m_txst = 0, m_rxst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete(); cmq.delete();
      m_state = 0; m_sck = 0; m_div = 0; m_bit = 0; m_left = 0;
      m_tx = 0; m_rx = 0; m_keep = 0; m_txsr = 0; m_rxsr = 0; m_txst = 0; m_rxst = 0;
    end else begin
      int tsz, rsz, csz, c;
      bit tpush, rpop, cpush;
      tsz = txq.size(); rsz = rxq.size(); csz = cmq.size();
      tpush = tx_wvalid && tsz < TXD;
      rpop = rx_rready && rsz > 0;
      cpush = cmd_valid && csz < CQD;
      m_txst = (m_state == 1 && m_tx != 0 && tsz == 0);
      m_rxst = (m_state == 1 && m_rx != 0 && rsz == RXD);
      case (m_state)
        0, 3: if (csz > 0) begin
          c = cmq.pop_front();
          m_left = c >> 3; m_tx = (c >> 2) & 1; m_rx = (c >> 1) & 1; m_keep = c & 1;
          m_state = 1;
        end
        1: if (!m_txst && !m_rxst) begin
          m_txsr = (m_tx != 0) ? txq.pop_front() : 0;
          m_div = 0; m_bit = 0; m_state = 2;
        end
        default: if (m_div == int'(cfg_div)) begin
          m_div = 0;
          if (m_sck == 0) begin
            m_rxsr = ((m_rxsr << 1) | int'(sd_i)) & 255;
            m_sck = 1;
          end else begin
            m_sck = 0;
            m_txsr = (m_txsr << 1) & 255;
            if (m_bit == 7) begin
              if (m_rx != 0) rxq.push_back(m_rxsr);
              m_bit = 0;
              if (m_left == 0) m_state = (m_keep != 0) ? 3 : 0;
              else begin m_left--; m_state = 1; end
            end else m_bit++;
          end
        end else m_div++;
      endcase
      if (rpop) void'(rxq.pop_front());
      if (tpush) txq.push_back(int'(tx_wdata));
      if (cpush) cmq.push_back(int'(cmd_len) * 8 + int'(cmd_tx) * 4 + int'(cmd_rx) * 2 + int'(cmd_keep));
    end
  end

  // slave stream and drain driver
  function automatic logic stream_bit(input int k);
    return ((k * 7 + 3) % 5) < 2;
  endfunction

  always @(negedge clk) begin
    if (prev_sck && !sck) idx++;
    prev_sck = sck;
    sd_i = stream_bit(idx);
    rx_rready = drain && rx_rvalid;
    if (rx_rready) rx_got++;
  end

  // per-cycle comparison
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      chk("R7", "csb", int'(csb), (m_state == 0) ? 1 : 0);
      chk("R2", "sck", int'(sck), m_sck);
      chk("R2", "sd_o", int'(sd_o), (m_txsr >> 7) & 1);
      chk("R4", "rx_stall", int'(rx_stall), m_rxst);
      chk("R5", "tx_stall", int'(tx_stall), m_txst);
      chk("R6", "hold_idle", int'(hold_idle), (m_state == 3) ? 1 : 0);
      chk("R9", "tx_qd", int'(tx_qd), txq.size());
      chk("R9", "rx_qd", int'(rx_qd), rxq.size());
      chk("R9", "tx_empty", int'(tx_empty), (txq.size() == 0) ? 1 : 0);
      chk("R9", "rx_full", int'(rx_full), (rxq.size() == RXD) ? 1 : 0);
      chk("R8", "tx_wm", int'(tx_wm), (txq.size() < int'(cfg_txwm)) ? 1 : 0);
      chk("R10", "tx_wready", int'(tx_wready), (txq.size() < TXD) ? 1 : 0);
      chk("R10", "cmd_ready", int'(cmd_ready), (cmq.size() < CQD) ? 1 : 0);
      chk("R10", "rx_rvalid", int'(rx_rvalid), (rxq.size() > 0) ? 1 : 0);
      if (rxq.size() > 0) chk("R3", "rx_rdata", int'(rx_rdata), rxq[0]);
      if (rx_stall) saw_rxst = 1;
      if (tx_stall) saw_txst = 1;
      if (hold_idle) saw_hold = 1;
      if (!cmd_ready) saw_cmdfull = 1;
    end
  end

  task automatic wr_tx(input int b);
    tx_wvalid = 1; tx_wdata = 8'(b);
    @(negedge clk);
    tx_wvalid = 0;
  endtask

  task automatic push_cmd(input int len, input bit t, input bit r, input bit k);
    cmd_valid = 1; cmd_len = LW'(len); cmd_tx = t; cmd_rx = r; cmd_keep = k;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((!csb || tx_stall || rx_stall || cmq.size() != 0) && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R1 reset state
    chk("R1", "csb after reset", int'(csb), 1);
    chk("R1", "sck after reset", int'(sck), 0);
    chk("R1", "sd_o after reset", int'(sd_o), 0);
    chk("R1", "stalls after reset", int'(tx_stall) + int'(rx_stall), 0);
    chk("R1", "hold after reset", int'(hold_idle), 0);
    chk("R1", "queues after reset", int'(tx_qd) + int'(rx_qd), 0);
    @(negedge clk);

    // keep-select segment then hold, then capture-only segment hitting RX full (R6, R4)
    wr_tx(8'hA5); wr_tx(8'h3C); wr_tx(8'h81); wr_tx(8'h7E);
    push_cmd(1, 1, 1, 1);
    repeat (200) @(negedge clk);
    chk("R6", "csb low in hold", int'(csb), 0);
    chk("R6", "hold_idle after keep segment", int'(hold_idle), 1);
    push_cmd(2, 0, 1, 0);
    repeat (300) @(negedge clk);
    chk("R4", "rx_stall while full", int'(rx_stall), 1);
    chk("R4", "sck held during rx stall", int'(sck), 0);
    drain = 1;
    wait_idle();
    repeat (20) @(negedge clk);
    drain = 0;

    // TX starvation with fast divider (R5)
    cfg_div = 0;
    cfg_txwm = 5;
    push_cmd(2, 1, 0, 0);
    repeat (150) @(negedge clk);
    chk("R5", "tx_stall while empty", int'(tx_stall), 1);
    chk("R5", "csb low during tx stall", int'(csb), 0);
    wr_tx(8'h12);
    repeat (40) @(negedge clk);
    wr_tx(8'hED);
    wait_idle();
    repeat (10) @(negedge clk);

    // FIFO overflow, queue full, chained segments (R10, R3, R8)
    cfg_div = 2;
    cfg_txwm = 2;
    drain = 1;
    for (int i = 0; i < TXD + 2; i++) wr_tx(i * 29 + 7);
    chk("R10", "tx_qd capped", int'(tx_qd), TXD);
    push_cmd(3, 1, 1, 1);
    push_cmd(1, 1, 0, 1);
    push_cmd(0, 1, 1, 0);
    push_cmd(0, 0, 1, 0);
    wait_idle();
    repeat (30) @(negedge clk);
    drain = 0;

    chk("R4", "rx stall seen", int'(saw_rxst), 1);
    chk("R5", "tx stall seen", int'(saw_txst), 1);
    chk("R6", "hold seen", int'(saw_hold), 1);
    chk("R10", "cmd queue full seen", int'(saw_cmdfull), 1);
    chk("R3", "bytes captured total", rx_got, 2 + 3 + 4 + 1);
    chk("R7", "csb released at end", int'(csb), 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule